// File: doc/BRIEF.md
# Two-Port RAM with Cross-Port Mailbox Interrupts

A synchronous two-port word memory with two independent ports, left and right, each able to read or write any word in every cycle. Each port has its own address, write-data and read-data buses, a select, a write strobe, and separate enables for the upper and lower byte lanes. The two highest word addresses are reserved as mailboxes. The left port owns address 2^ADDR_W-2 and the right port owns address 2^ADDR_W-1. With ADDR_W set to 16, these are 0xFFFE and 0xFFFF.

When one port writes into the other port's mailbox, the mailbox owner receives an active-low interrupt. The owner clears the interrupt by reading its own mailbox. Mailbox words also store data like any other word, so a message can travel with the interrupt. Each port has an active-low busy input. When a port's busy input is active, that port's mailbox write does not raise the interrupt, although the data is still stored.

Top module: `dpm_mailbox_ram`

## Requirements
- R1: While rst_ni is low, both interrupt outputs are high and both read-data outputs are zero. Reset is asynchronous.
- R2: A read (select high, write strobe low) presents the addressed word on that port's read-data output after the next rising clock edge. The read-data output holds its value in every cycle without a read.
- R3: The upper byte enable writes data bits [15:8] and the lower byte enable writes bits [7:0]. A disabled lane keeps its stored byte.
- R4: When both ports write the same word in the same cycle, each byte lane takes the left port's data if the left lane is enabled, and otherwise the right port's data.
- R5: A read in the same cycle as a write to the same word by the other port returns the contents from before that write.
- R6: A left-port write to address 2^ADDR_W-1 drives r_irq_no low after that clock edge.
- R7: A right-port write to address 2^ADDR_W-2 drives l_irq_no low after that clock edge.
- R8: A read by a port of its own mailbox address drives that port's interrupt output high after that clock edge.
- R9: A read by a port of the other port's mailbox leaves both interrupt outputs unchanged.
- R10: A mailbox write made while the writer's busy input is low does not change the owner's interrupt. The word is still written.
- R11: When the owner reads its mailbox in the same cycle that the other port writes it, the interrupt becomes or stays active.
- R12: A mailbox write sets the interrupt for any byte-enable pattern, including both enables low. The stored word changes only in the enabled lanes.
- R13: A write by a port to its own mailbox does not change either interrupt output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_cs_i | input | 1 | Left port select |
| l_we_i | input | 1 | Left write strobe (1 write, 0 read) |
| l_ube_i | input | 1 | Left upper byte enable |
| l_lbe_i | input | 1 | Left lower byte enable |
| l_addr_i | input | ADDR_W | Left word address |
| l_wdata_i | input | DATA_W | Left write data |
| l_busy_ni | input | 1 | Left busy, active low |
| l_rdata_o | output | DATA_W | Left read data |
| l_irq_no | output | 1 | Left mailbox interrupt, active low |
| r_cs_i | input | 1 | Right port select |
| r_we_i | input | 1 | Right write strobe (1 write, 0 read) |
| r_ube_i | input | 1 | Right upper byte enable |
| r_lbe_i | input | 1 | Right lower byte enable |
| r_addr_i | input | ADDR_W | Right word address |
| r_wdata_i | input | DATA_W | Right write data |
| r_busy_ni | input | 1 | Right busy, active low |
| r_rdata_o | output | DATA_W | Right read data |
| r_irq_no | output | 1 | Right mailbox interrupt, active low |

## Verification
The bench targets the cycles where two rules meet:
- The owner's clearing read coincides with the other port's setting write. A design with the priority reversed would leave the interrupt inactive.
- A blocked write occurs with busy low. A design that ignored busy would raise the interrupt, and a design that also gated the store would lose the data.
- The bench covers reads of the other port's mailbox, writes to a port's own mailbox, and mailbox writes with no byte lane enabled. A sloppy decode would clear, set or skip the interrupt in these cases.
- Same-cycle writes to the same word show whether the left port wins lane by lane. Reads that race a write show whether old data is returned.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
  localparam int unsigned NUM_PORTS = 2;
  localparam int unsigned NUM_LANES = 2;

  typedef enum logic {
    SIDE_L = 1'b0,
    SIDE_R = 1'b1
  } side_e;

  typedef struct packed {
    logic wr;
    logic rd;
    logic at_own;
    logic at_peer;
  } acc_s;
endpackage

// File: rtl/dpm_port_decode.sv
module dpm_port_decode #(
  parameter int unsigned         ADDR_W   = 10,
  parameter logic [ADDR_W-1:0]   OWN_MBX  = '1,
  parameter logic [ADDR_W-1:0]   PEER_MBX = '0
) (
  input  logic              cs_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output dpm_pkg::acc_s     acc_o
);
  always_comb begin
    acc_o.wr      = cs_i & we_i;
    acc_o.rd      = cs_i & ~we_i;
    acc_o.at_own  = (addr_i == OWN_MBX);
    acc_o.at_peer = (addr_i == PEER_MBX);
  end
endmodule

// File: rtl/dpm_mbox_flag.sv
module dpm_mbox_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  // set beats clear when both land in one cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/dpm_mem_array.sv
module dpm_mem_array #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [dpm_pkg::NUM_PORTS-1:0] we_i,
  input  logic [dpm_pkg::NUM_PORTS-1:0] re_i,
  input  logic [dpm_pkg::NUM_LANES-1:0] be_i    [dpm_pkg::NUM_PORTS],
  input  logic [ADDR_W-1:0]             addr_i  [dpm_pkg::NUM_PORTS],
  input  logic [DATA_W-1:0]             wdata_i [dpm_pkg::NUM_PORTS],
  output logic [DATA_W-1:0]             rdata_o [dpm_pkg::NUM_PORTS]
);
  localparam int unsigned DEPTH  = 1 << ADDR_W;
  localparam int unsigned LANES  = dpm_pkg::NUM_LANES;
  localparam int unsigned LANE_W = DATA_W / LANES;

  logic [DATA_W-1:0] mem_q [DEPTH];

  // right applied first, left last: left wins per lane
  always_ff @(posedge clk_i) begin
    for (int p = dpm_pkg::NUM_PORTS - 1; p >= 0; p--) begin
      if (we_i[p]) begin
        for (int k = 0; k < LANES; k++) begin
          if (be_i[p][k]) mem_q[addr_i[p]][k*LANE_W +: LANE_W] <= wdata_i[p][k*LANE_W +: LANE_W];
        end
      end
    end
  end

  for (genvar p = 0; p < dpm_pkg::NUM_PORTS; p++) begin : g_rd
    logic [DATA_W-1:0] rdata_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      rdata_q <= '0;
      else if (re_i[p]) rdata_q <= mem_q[addr_i[p]];
    end
    assign rdata_o[p] = rdata_q;
  end
endmodule

// File: rtl/dpm_mailbox_ram.sv
module dpm_mailbox_ram #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_cs_i,
  input  logic              l_we_i,
  input  logic              l_ube_i,
  input  logic              l_lbe_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic [DATA_W-1:0] l_wdata_i,
  input  logic              l_busy_ni,
  output logic [DATA_W-1:0] l_rdata_o,
  output logic              l_irq_no,
  input  logic              r_cs_i,
  input  logic              r_we_i,
  input  logic              r_ube_i,
  input  logic              r_lbe_i,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic [DATA_W-1:0] r_wdata_i,
  input  logic              r_busy_ni,
  output logic [DATA_W-1:0] r_rdata_o,
  output logic              r_irq_no
);
  import dpm_pkg::*;

  localparam logic [ADDR_W-1:0] MBX_R = '1;
  localparam logic [ADDR_W-1:0] MBX_L = MBX_R - 1'b1;

  logic [NUM_PORTS-1:0] cs, we, busy_n, wr, rd, irq;
  logic [NUM_LANES-1:0] be    [NUM_PORTS];
  logic [ADDR_W-1:0]    addr  [NUM_PORTS];
  logic [DATA_W-1:0]    wdata [NUM_PORTS];
  logic [DATA_W-1:0]    rdata [NUM_PORTS];
  acc_s                 acc   [NUM_PORTS];

  always_comb begin
    cs[SIDE_L]     = l_cs_i;
    cs[SIDE_R]     = r_cs_i;
    we[SIDE_L]     = l_we_i;
    we[SIDE_R]     = r_we_i;
    busy_n[SIDE_L] = l_busy_ni;
    busy_n[SIDE_R] = r_busy_ni;
    be[SIDE_L]     = {l_ube_i, l_lbe_i};
    be[SIDE_R]     = {r_ube_i, r_lbe_i};
    addr[SIDE_L]   = l_addr_i;
    addr[SIDE_R]   = r_addr_i;
    wdata[SIDE_L]  = l_wdata_i;
    wdata[SIDE_R]  = r_wdata_i;
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam int unsigned      PEER = NUM_PORTS - 1 - p;
    localparam logic [ADDR_W-1:0] OWN_A  = (p == int'(SIDE_L)) ? MBX_L : MBX_R;
    localparam logic [ADDR_W-1:0] PEER_A = (p == int'(SIDE_L)) ? MBX_R : MBX_L;

    dpm_port_decode #(
      .ADDR_W  (ADDR_W),
      .OWN_MBX (OWN_A),
      .PEER_MBX(PEER_A)
    ) u_dec (
      .cs_i  (cs[p]),
      .we_i  (we[p]),
      .addr_i(addr[p]),
      .acc_o (acc[p])
    );

    assign wr[p] = acc[p].wr;
    assign rd[p] = acc[p].rd;

    // peer's write into our mailbox, unless peer is held busy
    dpm_mbox_flag u_flag (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (acc[PEER].wr & acc[PEER].at_peer & busy_n[PEER]),
      .clr_i (acc[p].rd & acc[p].at_own),
      .flag_o(irq[p])
    );
  end

  dpm_mem_array #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_mem (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr),
    .re_i   (rd),
    .be_i   (be),
    .addr_i (addr),
    .wdata_i(wdata),
    .rdata_o(rdata)
  );

  assign l_rdata_o = rdata[SIDE_L];
  assign r_rdata_o = rdata[SIDE_R];
  assign l_irq_no  = ~irq[SIDE_L];
  assign r_irq_no  = ~irq[SIDE_R];
endmodule

// File: rtl/dpm_mailbox_ram_chk.sv
module dpm_mailbox_ram_chk #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              l_cs_i,
  input logic              l_we_i,
  input logic              l_ube_i,
  input logic              l_lbe_i,
  input logic [ADDR_W-1:0] l_addr_i,
  input logic [DATA_W-1:0] l_wdata_i,
  input logic              l_busy_ni,
  input logic [DATA_W-1:0] l_rdata_o,
  input logic              l_irq_no,
  input logic              r_cs_i,
  input logic              r_we_i,
  input logic              r_ube_i,
  input logic              r_lbe_i,
  input logic [ADDR_W-1:0] r_addr_i,
  input logic [DATA_W-1:0] r_wdata_i,
  input logic              r_busy_ni,
  input logic [DATA_W-1:0] r_rdata_o,
  input logic              r_irq_no
);
  localparam logic [ADDR_W-1:0] MBX_R = '1;
  localparam logic [ADDR_W-1:0] MBX_L = MBX_R - 1'b1;

  logic l_wr_rmb, l_rd_lmb, l_rd_rmb, r_wr_lmb, r_rd_rmb, r_rd_lmb;
  assign l_wr_rmb = l_cs_i & l_we_i & (l_addr_i == MBX_R);
  assign r_wr_lmb = r_cs_i & r_we_i & (r_addr_i == MBX_L);
  assign l_rd_lmb = l_cs_i & ~l_we_i & (l_addr_i == MBX_L);
  assign l_rd_rmb = l_cs_i & ~l_we_i & (l_addr_i == MBX_R);
  assign r_rd_rmb = r_cs_i & ~r_we_i & (r_addr_i == MBX_R);
  assign r_rd_lmb = r_cs_i & ~r_we_i & (r_addr_i == MBX_L);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_idle_R1: assert (l_irq_no === 1'b1 && r_irq_no === 1'b1 &&
                                    l_rdata_o === '0 && r_rdata_o === '0);
    end
  end

  assert_rdata_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(l_cs_i && !l_we_i) |=> $stable(l_rdata_o));

  assert_set_right_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_wr_rmb && l_busy_ni) |=> !r_irq_no);

  assert_set_left_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_wr_lmb && r_busy_ni) |=> !l_irq_no);

  assert_clear_left_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_rd_lmb && !r_wr_lmb) |=> l_irq_no);

  assert_peer_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_rd_rmb && !r_rd_rmb) |=> $stable(r_irq_no));

  assert_busy_block_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_wr_lmb && !r_busy_ni && !l_rd_lmb) |=> $stable(l_irq_no));

  assert_set_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_rd_rmb && l_wr_rmb && l_busy_ni) |=> !r_irq_no);

  assert_peer_read_r_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_rd_lmb && !l_rd_lmb) |=> $stable(l_irq_no));
endmodule

bind dpm_mailbox_ram dpm_mailbox_ram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/dpm_mailbox_ram_test.sv
module dpm_mailbox_ram_test;
  localparam int AW = 10;
  localparam int DW = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic l_cs_i, l_we_i, l_ube_i, l_lbe_i, l_busy_ni;
  logic r_cs_i, r_we_i, r_ube_i, r_lbe_i, r_busy_ni;
  logic [AW-1:0] l_addr_i, r_addr_i;
  logic [DW-1:0] l_wdata_i, r_wdata_i, l_rdata_o, r_rdata_o;
  logic l_irq_no, r_irq_no;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  dpm_mailbox_ram #(.ADDR_W(AW), .DATA_W(DW)) uut (.*);

  typedef struct packed {
    logic lcs, lwe, lbsy; logic [1:0] lbe; logic [AW-1:0] la; logic [DW-1:0] lwd;
    logic rcs, rwe, rbsy; logic [1:0] rbe; logic [AW-1:0] ra; logic [DW-1:0] rwd;
    logic el, er;
    logic cl; logic [DW-1:0] elr;
    logic cr; logic [DW-1:0] err;
    logic [23:0] tag;
  } vec_t;

  // be = {upper, lower}; left mailbox 10'h3FE, right mailbox 10'h3FF
  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b1,1'b1,2'b11,10'h010,16'hA5C3, 1'b0,1'b0,1'b1,2'b00,10'h000,16'h0000, 1'b1,1'b1, 1'b0,16'h0000, 1'b0,16'h0000, "R3"},
    '{1'b1,1'b0,1'b1,2'b00,10'h010,16'h0000, 1'b1,1'b1,1'b1,2'b01,10'h010,16'h1234, 1'b1,1'b1, 1'b1,16'hA5C3, 1'b0,16'h0000, "R5"},
    '{1'b0,1'b0,1'b1,2'b00,10'h000,16'h0000, 1'b1,1'b0,1'b1,2'b00,10'h010,16'h0000, 1'b1,1'b1, 1'b0,16'h0000, 1'b1,16'hA534, "R3"},
    '{1'b1,1'b1,1'b1,2'b10,10'h020,16'h1111, 1'b1,1'b1,1'b1,2'b11,10'h020,16'h2222, 1'b1,1'b1, 1'b0,16'h0000, 1'b0,16'h0000, "R4"},
    '{1'b1,1'b0,1'b1,2'b00,10'h020,16'h0000, 1'b0,1'b0,1'b1,2'b00,10'h000,16'h0000, 1'b1,1'b1, 1'b1,16'h1122, 1'b0,16'h0000, "R4"},
    '{1'b1,1'b1,1'b1,2'b11,10'h3FF,16'hBEEF, 1'b0,1'b0,1'b1,2'b00,10'h000,16'h0000, 1'b1,1'b0, 1'b0,16'h0000, 1'b0,16'h0000, "R6"},
    '{1'b1,1'b0,1'b1,2'b00,10'h3FF,16'h0000, 1'b0,1'b0,1'b1,2'b00,10'h000,16'h0000, 1'b1,1'b0, 1'b1,16'hBEEF, 1'b0,16'h0000, "R9"},
    '{1'b0,1'b0,1'b1,2'b00,10'h000,16'h0000, 1'b1,1'b0,1'b1,2'b00,10'h3FF,16'h0000, 1'b1,1'b1, 1'b0,16'h0000, 1'b1,16'hBEEF, "R8"},
    '{1'b0,1'b0,1'b1,2'b00,10'h000,16'h0000, 1'b1,1'b1,1'b1,2'b11,10'h3FE,16'h0F0F, 1'b0,1'b1, 1'b0,16'h0000, 1'b0,16'h0000, "R7"},
    '{1'b1,1'b1,1'b1,2'b11,10'h3FE,16'h7777, 1'b0,1'b0,1'b1,2'b00,10'h000,16'h0000, 1'b0,1'b1, 1'b0,16'h0000, 1'b0,16'h0000, "R13"},
    '{1'b1,1'b0,1'b1,2'b00,10'h3FE,16'h0000, 1'b0,1'b0,1'b1,2'b00,10'h000,16'h0000, 1'b1,1'b1, 1'b1,16'h7777, 1'b0,16'h0000, "R8"},
    '{1'b1,1'b1,1'b0,2'b11,10'h3FF,16'h5555, 1'b0,1'b0,1'b1,2'b00,10'h000,16'h0000, 1'b1,1'b1, 1'b0,16'h0000, 1'b0,16'h0000, "R10"},
    '{1'b0,1'b0,1'b1,2'b00,10'h000,16'h0000, 1'b1,1'b0,1'b1,2'b00,10'h3FF,16'h0000, 1'b1,1'b1, 1'b0,16'h0000, 1'b1,16'h5555, "R10"},
    '{1'b0,1'b0,1'b1,2'b00,10'h000,16'h0000, 1'b1,1'b1,1'b1,2'b00,10'h3FE,16'hAAAA, 1'b0,1'b1, 1'b0,16'h0000, 1'b0,16'h0000, "R12"},
    '{1'b1,1'b0,1'b1,2'b00,10'h3FE,16'h0000, 1'b0,1'b0,1'b1,2'b00,10'h000,16'h0000, 1'b1,1'b1, 1'b1,16'h7777, 1'b0,16'h0000, "R12"},
    '{1'b1,1'b0,1'b1,2'b00,10'h3FE,16'h0000, 1'b1,1'b1,1'b1,2'b01,10'h3FE,16'h00CC, 1'b0,1'b1, 1'b1,16'h7777, 1'b0,16'h0000, "R11"},
    '{1'b1,1'b0,1'b1,2'b00,10'h3FE,16'h0000, 1'b0,1'b0,1'b1,2'b00,10'h000,16'h0000, 1'b1,1'b1, 1'b1,16'h77CC, 1'b0,16'h0000, "R8"},
    '{1'b0,1'b0,1'b1,2'b00,10'h000,16'h0000, 1'b0,1'b0,1'b1,2'b00,10'h000,16'h0000, 1'b1,1'b1, 1'b1,16'h77CC, 1'b0,16'h0000, "R2"},
    '{1'b0,1'b0,1'b1,2'b00,10'h000,16'h0000, 1'b1,1'b1,1'b1,2'b11,10'h3FE,16'h1357, 1'b0,1'b1, 1'b0,16'h0000, 1'b0,16'h0000, "R7"},
    '{1'b0,1'b0,1'b1,2'b00,10'h000,16'h0000, 1'b1,1'b0,1'b1,2'b00,10'h3FE,16'h0000, 1'b0,1'b1, 1'b0,16'h0000, 1'b1,16'h1357, "R9"},
    '{1'b1,1'b0,1'b1,2'b00,10'h3FE,16'h0000, 1'b0,1'b0,1'b1,2'b00,10'h000,16'h0000, 1'b1,1'b1, 1'b1,16'h1357, 1'b0,16'h0000, "R8"},
    '{1'b0,1'b0,1'b1,2'b00,10'h000,16'h0000, 1'b1,1'b1,1'b1,2'b11,10'h3FF,16'h2468, 1'b1,1'b1, 1'b0,16'h0000, 1'b0,16'h0000, "R13"},
    '{1'b0,1'b0,1'b1,2'b00,10'h000,16'h0000, 1'b1,1'b0,1'b1,2'b00,10'h3FF,16'h0000, 1'b1,1'b1, 1'b0,16'h0000, 1'b1,16'h2468, "R13"}
  };

  task automatic check(input string tag, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    l_cs_i = v.lcs; l_we_i = v.lwe; l_busy_ni = v.lbsy; {l_ube_i, l_lbe_i} = v.lbe;
    l_addr_i = v.la; l_wdata_i = v.lwd;
    r_cs_i = v.rcs; r_we_i = v.rwe; r_busy_ni = v.rbsy; {r_ube_i, r_lbe_i} = v.rbe;
    r_addr_i = v.ra; r_wdata_i = v.rwd;
  endtask

  task automatic idle();
    l_cs_i = 0; l_we_i = 0; l_busy_ni = 1; l_ube_i = 0; l_lbe_i = 0; l_addr_i = '0; l_wdata_i = '0;
    r_cs_i = 0; r_we_i = 0; r_busy_ni = 1; r_ube_i = 0; r_lbe_i = 0; r_addr_i = '0; r_wdata_i = '0;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk_i);
    // R1 during reset
    check("R1", "l_irq_no", {15'd0, l_irq_no}, 16'd1);
    check("R1", "r_irq_no", {15'd0, r_irq_no}, 16'd1);
    check("R1", "l_rdata", l_rdata_o, 16'h0000);
    check("R1", "r_rdata", r_rdata_o, 16'h0000);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(negedge clk_i);
      check(string'(VECS[i].tag), "l_irq_no", {15'd0, l_irq_no}, {15'd0, VECS[i].el});
      check(string'(VECS[i].tag), "r_irq_no", {15'd0, r_irq_no}, {15'd0, VECS[i].er});
      if (VECS[i].cl) check(string'(VECS[i].tag), "l_rdata", l_rdata_o, VECS[i].elr);
      if (VECS[i].cr) check(string'(VECS[i].tag), "r_rdata", r_rdata_o, VECS[i].err);
    end

    // R6 then R1: async reset drops a pending interrupt and read data
    idle();
    l_cs_i = 1; l_we_i = 1; l_ube_i = 1; l_lbe_i = 1; l_addr_i = 10'h3FF; l_wdata_i = 16'h9999;
    @(negedge clk_i);
    check("R6", "r_irq_no", {15'd0, r_irq_no}, 16'd0);
    idle();
    r_cs_i = 1; r_addr_i = 10'h010;
    @(negedge clk_i);
    check("R2", "r_rdata", r_rdata_o, 16'hA534);
    idle();
    #3 rst_ni = 1'b0;
    #2;
    check("R1", "r_irq_no async", {15'd0, r_irq_no}, 16'd1);
    check("R1", "r_rdata async", r_rdata_o, 16'h0000);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", "r_irq_no after", {15'd0, r_irq_no}, 16'd1);

    // R10: blocked right write to left mailbox, data kept
    r_cs_i = 1; r_we_i = 1; r_busy_ni = 0; r_ube_i = 1; r_lbe_i = 1; r_addr_i = 10'h3FE; r_wdata_i = 16'hC0DE;
    @(negedge clk_i);
    check("R10", "l_irq_no", {15'd0, l_irq_no}, 16'd1);
    idle();
    l_cs_i = 1; l_addr_i = 10'h3FE;
    @(negedge clk_i);
    check("R10", "l_rdata", l_rdata_o, 16'hC0DE);
    idle();
    @(negedge clk_i);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule